// File: doc/BRIEF.md
# System Clock Source Selector with Security Fallback

This controller chooses which of three candidate clocks drives the system clock: an internal RC oscillator, an external crystal oscillator, or a PLL output. Software places a two-bit source code on the request input. The controller moves to that source only after the source signals that it is ready. The source actually in use comes out on a separate status output, so software can poll until status and request agree. The controller drives a one-hot select towards a glitch-free clock mux, which lives outside this block.

The security path watches a failure-detect input for the external oscillator. When security is enabled and the external oscillator is feeding the system clock, either directly or as the PLL reference, a failure has four effects. It forces the selection back to the internal oscillator, forces the external oscillator off, and raises a sticky interrupt flag. Software must then present a different request before the controller leaves the internal oscillator. A wake-up event from a low-power state also forces the internal oscillator in the same way, but raises no flag.

The ready inputs and the failure input arrive from other clock domains. Each passes through a flip-flop chain whose length is set by a parameter before the controller uses it.

Top module: `sysclk_switch`

## Requirements
- R1: During and after reset, status is 00, the one-hot select is 001, and both the security interrupt and the forced oscillator disable are low.
- R2: Source codes are 00 internal, 01 external and 10 PLL; a request of 11 is treated as internal. The select is one-hot with bit 0 internal, bit 1 external and bit 2 PLL, and it always matches the status.
- R3: When the requested source is already ready (after synchronisation), status takes the requested code one clock after the request is applied.
- R4: A request for a source that is not ready leaves status unchanged. The switch happens without further software action once that source's ready flag comes through.
- R5: With security enabled, a synchronised failure while status is external, or while status is PLL with the PLL referenced to the external oscillator, forces status to 00 on the following clock.
- R6: That failure also sets the interrupt flag and the oscillator disable. Both stay high until an interrupt-clear strobe, and both drop on the clock after the strobe. If a failure and a clear fall in the same clock, the failure wins.
- R7: A failure while security is disabled, while status is internal, or while the PLL is referenced to the internal oscillator changes neither status nor the flag.
- R8: After a forced fallback, status stays 00 even if the old request's source is ready. It leaves 00 only after the request input takes a value different from the one present at the fallback.
- R9: A wake-up pulse forces status to 00 on the next clock and applies the same hold as R8.
- R10: Ready and failure inputs pass through SYNC_STAGES flip-flops. A ready edge applied just after a clock edge moves status no earlier than SYNC_STAGES+1 clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_src_i | input | 2 | Requested source code from software |
| rdy_raw_i | input | 3 | Asynchronous ready flags, bit 0 internal, bit 1 external, bit 2 PLL |
| pll_ref_ext_i | input | 1 | High when the PLL is referenced to the external oscillator |
| sec_en_i | input | 1 | Enables the clock security fallback |
| fail_raw_i | input | 1 | Asynchronous external-oscillator failure indication |
| irq_clr_i | input | 1 | Strobe that clears the security interrupt and the forced disable |
| wake_i | input | 1 | Wake-up from a low-power state, one clock pulse |
| stat_src_o | output | 2 | Source actually in use |
| sel_onehot_o | output | 3 | One-hot mux select |
| xtal_kill_o | output | 1 | Forces the external oscillator off |
| sec_irq_o | output | 1 | Sticky security interrupt flag |

## Verification
The bench builds the controller with its default of two synchroniser stages. Every latency it expects follows from that: three clocks from a raw ready edge or failure pulse to the status change, and one clock from a request to a source that is already ready. With this depth the bench can observe the status just before a deferred switch completes, and so show that no switch happens ahead of the synchroniser. It also drives the two fallback routes (direct external and PLL from external), the ignored-failure cases, the stale-request hold and wake-up.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    localparam int NUM_SRC = 3;
    localparam int CODE_W  = 2;

    typedef enum logic [CODE_W-1:0] {
        SRC_INT = 2'b00,
        SRC_EXT = 2'b01,
        SRC_PLL = 2'b10
    } src_e;

    // Unused code 11 maps to the internal oscillator.
    function automatic src_e decode_req(input logic [CODE_W-1:0] code);
        case (code)
            2'b01:   return SRC_EXT;
            2'b10:   return SRC_PLL;
            default: return SRC_INT;
        endcase
    endfunction

    function automatic logic [NUM_SRC-1:0] src_onehot(input src_e s);
        logic [NUM_SRC-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

    // True when the running clock depends on the external oscillator.
    function automatic logic uses_xtal(input src_e s, input logic pll_ext);
        return (s == SRC_EXT) || ((s == SRC_PLL) && pll_ext);
    endfunction

endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d_i;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[g] <= '0;
            else     chain[g] <= chain[g-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clksel_guard.sv
module clksel_guard
    import clksel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_e cur_i,
    input  logic pll_ref_ext_i,
    input  logic sec_en_i,
    input  logic fail_s_i,
    input  logic irq_clr_i,
    output logic fault_o,
    output logic sec_irq_o,
    output logic xtal_kill_o
);
    assign fault_o = sec_en_i && fail_s_i && uses_xtal(cur_i, pll_ref_ext_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_irq_o   <= 1'b0;
            xtal_kill_o <= 1'b0;
        end else if (fault_o) begin
            sec_irq_o   <= 1'b1;
            xtal_kill_o <= 1'b1;
        end else if (irq_clr_i) begin
            sec_irq_o   <= 1'b0;
            xtal_kill_o <= 1'b0;
        end
    end
endmodule

// File: rtl/clksel_core.sv
module clksel_core
    import clksel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [CODE_W-1:0]  req_i,
    input  logic [NUM_SRC-1:0] rdy_s_i,
    input  logic               force_i,
    output src_e               cur_o
);
    logic              hold_q;
    logic [CODE_W-1:0] snap_q;
    logic              hold_eff;
    src_e              tgt;

    // Hold persists only while the request equals the value seen at fallback.
    assign hold_eff = hold_q && (req_i == snap_q);
    assign tgt      = hold_eff ? SRC_INT : decode_req(req_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_o  <= SRC_INT;
            hold_q <= 1'b0;
            snap_q <= '0;
        end else if (force_i) begin
            cur_o  <= SRC_INT;
            hold_q <= 1'b1;
            snap_q <= req_i;
        end else begin
            hold_q <= hold_eff;
            if ((tgt != cur_o) && rdy_s_i[tgt])
                cur_o <= tgt;
        end
    end
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   req_src_i,
    input  logic [2:0]   rdy_raw_i,
    input  logic         pll_ref_ext_i,
    input  logic         sec_en_i,
    input  logic         fail_raw_i,
    input  logic         irq_clr_i,
    input  logic         wake_i,
    output logic [1:0]   stat_src_o,
    output logic [2:0]   sel_onehot_o,
    output logic         xtal_kill_o,
    output logic         sec_irq_o
);
    localparam int SYNC_W = NUM_SRC + 1;

    logic [SYNC_W-1:0]  sync_q;
    logic [NUM_SRC-1:0] rdy_s;
    logic               fail_s;
    logic               fault;
    src_e               cur;

    clksel_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({fail_raw_i, rdy_raw_i}),
        .q_o (sync_q)
    );

    assign rdy_s  = sync_q[NUM_SRC-1:0];
    assign fail_s = sync_q[NUM_SRC];

    clksel_guard u_guard (
        .clk           (clk),
        .rst           (rst),
        .cur_i         (cur),
        .pll_ref_ext_i (pll_ref_ext_i),
        .sec_en_i      (sec_en_i),
        .fail_s_i      (fail_s),
        .irq_clr_i     (irq_clr_i),
        .fault_o       (fault),
        .sec_irq_o     (sec_irq_o),
        .xtal_kill_o   (xtal_kill_o)
    );

    clksel_core u_core (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_src_i),
        .rdy_s_i (rdy_s),
        .force_i (fault || wake_i),
        .cur_o   (cur)
    );

    assign stat_src_o   = cur;
    assign sel_onehot_o = src_onehot(cur);
endmodule

// File: rtl/clksel_chk.sv
module clksel_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] stat,
    input logic [2:0] sel,
    input logic [2:0] rdy_s,
    input logic       fault,
    input logic       wake,
    input logic       irq,
    input logic       irq_clr,
    input logic       kill
);
    logic [2:0] rdy_prev;
    always_ff @(posedge clk) rdy_prev <= rdy_s;

    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);

    a_r3_switch_needs_ready: assert property (@(posedge clk) disable iff (rst)
        (stat != $past(stat)) && (stat != 2'b00) |-> rdy_prev[stat]);

    a_r5_fault_falls_back: assert property (@(posedge clk) disable iff (rst)
        fault |=> (stat == 2'b00) && irq && kill);

    a_r6_irq_sticky: assert property (@(posedge clk) disable iff (rst)
        irq && !irq_clr |=> irq);

    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        irq_clr && !fault |=> !irq && !kill);

    a_r9_wake_forces_int: assert property (@(posedge clk) disable iff (rst)
        wake |=> stat == 2'b00);
endmodule

bind sysclk_switch clksel_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .stat    (stat_src_o),
    .sel     (sel_onehot_o),
    .rdy_s   (rdy_s),
    .fault   (fault),
    .wake    (wake_i),
    .irq     (sec_irq_o),
    .irq_clr (irq_clr_i),
    .kill    (xtal_kill_o)
);

// File: tb/sim_sysclk_switch.sv
module sim_sysclk_switch;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] req_src;
    logic [2:0] rdy_raw;
    logic       pll_ref_ext, sec_en, fail_raw, irq_clr, wake;
    logic [1:0] stat_src;
    logic [2:0] sel_onehot;
    logic       xtal_kill, sec_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysclk_switch #(.SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst(rst), .req_src_i(req_src), .rdy_raw_i(rdy_raw),
        .pll_ref_ext_i(pll_ref_ext), .sec_en_i(sec_en), .fail_raw_i(fail_raw),
        .irq_clr_i(irq_clr), .wake_i(wake), .stat_src_o(stat_src),
        .sel_onehot_o(sel_onehot), .xtal_kill_o(xtal_kill), .sec_irq_o(sec_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fail_pulse();
        fail_raw = 1'b1;
        cyc(1);
        fail_raw = 1'b0;
        cyc(SYNC);
    endtask

    task automatic clear_irq();
        irq_clr = 1'b1;
        cyc(1);
        irq_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1; req_src = 2'b00; rdy_raw = 3'b001; pll_ref_ext = 1'b0;
        sec_en = 1'b0; fail_raw = 1'b0; irq_clr = 1'b0; wake = 1'b0;
        cyc(3);
        check("R1 status in reset", stat_src, 0);
        rst = 1'b0;
        cyc(1);
        check("R1 status", stat_src, 0);
        check("R1 select", sel_onehot, 3'b001);
        check("R1 irq", sec_irq, 0);
        check("R1 kill", xtal_kill, 0);
    endtask

    task automatic t_request_ready();
        rdy_raw = 3'b011;
        cyc(SYNC + 1);
        req_src = 2'b11;
        cyc(3);
        check("R2 code 11 is internal", stat_src, 0);
        req_src = 2'b01;
        cyc(1);
        check("R3 switch to ready external", stat_src, 1);
        check("R2 select external", sel_onehot, 3'b010);
    endtask

    task automatic t_deferred();
        req_src = 2'b10;
        cyc(5);
        check("R4 not-ready PLL pending", stat_src, 1);
        rdy_raw = 3'b111;
        cyc(SYNC);
        check("R10 no switch before sync", stat_src, 1);
        cyc(1);
        check("R4 switch once ready", stat_src, 2);
        check("R2 select PLL", sel_onehot, 3'b100);
    endtask

    task automatic t_fail_pll_ext();
        pll_ref_ext = 1'b1; sec_en = 1'b1;
        fail_pulse();
        check("R5 PLL-from-external fallback", stat_src, 0);
        check("R6 irq set", sec_irq, 1);
        check("R6 kill set", xtal_kill, 1);
        cyc(4);
        check("R8 stale PLL request held off", stat_src, 0);
        check("R6 irq sticky", sec_irq, 1);
        clear_irq();
        check("R6 irq cleared", sec_irq, 0);
        check("R6 kill cleared", xtal_kill, 0);
        req_src = 2'b01;
        cyc(1);
        check("R8 new request leaves internal", stat_src, 1);
    endtask

    task automatic t_fail_direct();
        fail_pulse();
        check("R5 direct external fallback", stat_src, 0);
        cyc(4);
        check("R8 stale external request discarded", stat_src, 0);
        clear_irq();
        req_src = 2'b10;
        cyc(1);
        check("R8 new PLL request", stat_src, 2);
    endtask

    task automatic t_ignored();
        pll_ref_ext = 1'b0;
        fail_pulse();
        cyc(2);
        check("R7 PLL-from-internal ignores failure", stat_src, 2);
        check("R7 no irq", sec_irq, 0);
        sec_en = 1'b0;
        req_src = 2'b01;
        cyc(1);
        check("R3 back to external", stat_src, 1);
        fail_pulse();
        cyc(2);
        check("R7 disabled security ignores failure", stat_src, 1);
        check("R7 no kill", xtal_kill, 0);
    endtask

    task automatic t_wake();
        req_src = 2'b10;
        cyc(1);
        check("R3 to PLL", stat_src, 2);
        wake = 1'b1;
        cyc(1);
        wake = 1'b0;
        check("R9 wake forces internal", stat_src, 0);
        cyc(3);
        check("R9 hold after wake", stat_src, 0);
        check("R9 wake raises no irq", sec_irq, 0);
        req_src = 2'b00;
        cyc(1);
        req_src = 2'b01;
        cyc(1);
        check("R9 leaves after new request", stat_src, 1);
        req_src = 2'b00;
        cyc(1);
        check("R3 back to internal", stat_src, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_request_ready();
        t_deferred();
        t_fail_pll_ext();
        t_fail_direct();
        t_ignored();
        t_wake();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule